// File: doc/BRIEF.md
# Converter Register Bus Target

This block is the two-wire serial target for a small data converter. It watches the clock and data lines of an I2C bus, finds start, repeated start and stop conditions, and moves address and data bytes in most-significant-bit-first order. It has no drivers of its own on the bus. It pulls the data line low through an output enable and never touches the clock line, so the target never stretches the clock.

The seven-bit target address is the fixed prefix `1001` followed by three strap inputs. A read returns up to three bytes. The conversion result comes first, high byte before low byte. The configuration byte follows, and every byte after that reads as FFh. The result word is captured when the read address is accepted, so both result bytes always belong to one conversion. A write holds one configuration byte. Only that first byte is acknowledged and passed on as a strobe, and later bytes are left unacknowledged. On the general-call address, data byte 06h is acknowledged and sends a one-cycle reset pulse to the rest of the converter, data byte 04h is acknowledged with no action, and every other data byte is refused. The high-speed master code is never acknowledged. It raises a high-speed flag that holds until the next stop condition.

Top module: `adc_i2c_target`

## Requirements
- R1: An address byte whose upper seven bits equal `1001` followed by `strap_i[2:0]` is acknowledged (data line pulled low in the ninth clock). Any other address that is neither 00h nor a high-speed code is not acknowledged, and the target then ignores the bus until the next start.
- R2: After a read address (bit 0 = 1), the target sends the result bits [15:8], then the result bits [7:0], then `cfg_i`, and then FFh for every further byte the master acknowledges.
- R3: The result word is latched when the read address is accepted. A change of `result_i` during the read does not change the bytes sent.
- R4: After a write address (bit 0 = 0), the first data byte is acknowledged and causes exactly one `cfg_wr_o` pulse with that byte on `cfg_wdata_o`. Later bytes in the same transfer are not acknowledged and cause no pulse.
- R5: The general-call address 00h is acknowledged. A following data byte 06h is acknowledged and causes exactly one `soft_rst_o` pulse.
- R6: A general-call data byte 04h is acknowledged and causes no reset pulse. Any general-call data byte other than 04h or 06h is not acknowledged.
- R7: An address byte of the form `00001xxx` is never acknowledged. It sets `hs_mode_o`, which stays high until the next stop condition clears it.
- R8: `sda_oe_o` changes only while the clock line is low.
- R9: A master not-acknowledge after a read byte releases the data line, and the target stays silent until the next start.
- R10: A start seen while a transfer is in progress (a repeated start) restarts address reception, and the following transfer works normally.
- R11: After reset and after a stop, `sda_oe_o`, `cfg_wr_o`, `soft_rst_o` and `hs_mode_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe_o | output | 1 | When high, the data pin is driven low |
| strap_i | input | 3 | Address strap bits, low three bits of the address |
| result_i | input | 16 | Latest conversion result, two's complement |
| cfg_i | input | 8 | Current configuration byte, returned on reads |
| cfg_wr_o | output | 1 | One-cycle strobe: a new configuration byte was written |
| cfg_wdata_o | output | 8 | Configuration byte that goes with `cfg_wr_o` |
| soft_rst_o | output | 1 | One-cycle pulse on the general-call reset command |
| hs_mode_o | output | 1 | High after a high-speed master code, until stop |

## Verification
Reads use random strap settings, random result words and random configuration bytes, with lengths from one to five bytes. This separates the byte order and the FFh filler from the count of bytes. A directed read changes the result input between the two result bytes, which shows whether the word was latched or sampled live. Writes with several data bytes, and general-call bytes drawn from the whole byte range, show whether acknowledgement is selective, because only 04h and 06h, and only the first write byte, may pull the data line. Addresses one bit away from the target address, high-speed codes, repeated starts and a master not-acknowledge followed by idle clocks check how the target gets in and out of a transfer.

// File: rtl/adc_i2c_pkg.sv
package adc_i2c_pkg;

    localparam int BYTE_W = 8;

    // Byte-level progress of the target
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } tgt_state_e;

    // Meaning of the byte being received
    typedef enum logic [1:0] {
        RK_ADDR,
        RK_WDATA,
        RK_GCALL
    } rx_kind_e;

    localparam logic [BYTE_W-1:0] GC_ADDR   = 8'h00;
    localparam logic [BYTE_W-1:0] GC_RESET  = 8'h06;
    localparam logic [BYTE_W-1:0] GC_KEEP   = 8'h04;
    localparam logic [BYTE_W-1:0] FILL_BYTE = 8'hFF;
    localparam logic [4:0]        HS_PREFIX = 5'b00001;

endpackage

// File: rtl/i2c_sync_bit.sv
module i2c_sync_bit #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic scl_prev_q, sda_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_s;
            sda_prev_q <= sda_s;
        end
    end

    always_comb begin
        scl_rise  = scl_s && !scl_prev_q;
        scl_fall  = !scl_s && scl_prev_q;
        start_evt = scl_s && scl_prev_q && sda_prev_q && !sda_s;
        stop_evt  = scl_s && scl_prev_q && !sda_prev_q && sda_s;
    end
endmodule

// File: rtl/adc_i2c_target.sv
module adc_i2c_target
    import adc_i2c_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         RESULT_W    = 16,
    parameter logic [3:0] ADDR_PREFIX = 4'b1001
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_oe_o,
    input  logic [2:0]          strap_i,
    input  logic [RESULT_W-1:0] result_i,
    input  logic [BYTE_W-1:0]   cfg_i,
    output logic                cfg_wr_o,
    output logic [BYTE_W-1:0]   cfg_wdata_o,
    output logic                soft_rst_o,
    output logic                hs_mode_o
);
    localparam int RES_BYTES = RESULT_W / BYTE_W;
    localparam int LAST_IDX  = RES_BYTES + 1;
    localparam int IDX_W     = $clog2(LAST_IDX + 1);
    localparam int CNT_W     = $clog2(BYTE_W + 1);

    typedef struct packed {
        tgt_state_e          st;
        rx_kind_e            kind;
        logic [CNT_W-1:0]    cnt;
        logic [BYTE_W-1:0]   sh;
        logic                oe;
        logic                rd;
        logic [IDX_W-1:0]    idx;
        logic [RESULT_W-1:0] lat;
        logic                wr_done;
        logic                cfg_wr;
        logic [BYTE_W-1:0]   wdata;
        logic                srst;
        logic                hs;
    } regs_t;

    // ---- line synchronizers, one per bus line ----
    logic [1:0] line_raw, line_s;
    assign line_raw = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        i2c_sync_bit #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (line_raw[g]),
            .q_o   (line_s[g])
        );
    end

    logic scl_s, sda_s;
    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    logic scl_rise, scl_fall, start_evt, stop_evt;

    i2c_bus_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    // ---- read byte selection ----
    function automatic logic [BYTE_W-1:0] tx_pick(input logic [IDX_W-1:0] idx,
                                                  input logic [RESULT_W-1:0] res,
                                                  input logic [BYTE_W-1:0] cfg);
        logic [RESULT_W-1:0] shifted;
        shifted = '0;
        if (int'(idx) < RES_BYTES) begin
            shifted = res >> (BYTE_W * (RES_BYTES - 1 - int'(idx)));
            return shifted[BYTE_W-1:0];
        end else if (int'(idx) == RES_BYTES) begin
            return cfg;
        end
        return FILL_BYTE;
    endfunction

    function automatic logic [IDX_W-1:0] idx_next(input logic [IDX_W-1:0] idx);
        if (idx == IDX_W'(LAST_IDX)) return idx;
        return idx + 1'b1;
    endfunction

    regs_t r_q, r_d;
    logic [BYTE_W-1:0] tx_byte;
    logic              addr_hit;

    always_comb begin
        tx_byte  = tx_pick(r_q.idx, r_q.lat, cfg_i);
        addr_hit = (r_q.sh[BYTE_W-1:1] == {ADDR_PREFIX, strap_i});

        r_d        = r_q;
        r_d.cfg_wr = 1'b0;
        r_d.srst   = 1'b0;

        if (stop_evt) begin
            r_d.st = ST_IDLE;
            r_d.oe = 1'b0;
            r_d.hs = 1'b0;
            r_d.rd = 1'b0;
        end else if (start_evt) begin
            r_d.st   = ST_RX;
            r_d.kind = RK_ADDR;
            r_d.cnt  = '0;
            r_d.oe   = 1'b0;
            r_d.rd   = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        r_d.sh  = {r_q.sh[BYTE_W-2:0], sda_s};
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (scl_fall && r_q.cnt == CNT_W'(BYTE_W)) begin
                        r_d.st = ST_RX_ACK;
                        unique case (r_q.kind)
                            RK_ADDR: begin
                                if (addr_hit) begin
                                    r_d.oe = 1'b1;
                                    if (r_q.sh[0]) begin
                                        r_d.rd  = 1'b1;
                                        r_d.lat = result_i;
                                        r_d.idx = '0;
                                    end else begin
                                        r_d.kind    = RK_WDATA;
                                        r_d.wr_done = 1'b0;
                                    end
                                end else if (r_q.sh == GC_ADDR) begin
                                    r_d.oe   = 1'b1;
                                    r_d.kind = RK_GCALL;
                                end else begin
                                    if (r_q.sh[BYTE_W-1:3] == HS_PREFIX) r_d.hs = 1'b1;
                                    r_d.st = ST_IDLE;
                                end
                            end
                            RK_WDATA: begin
                                if (!r_q.wr_done) begin
                                    r_d.oe      = 1'b1;
                                    r_d.cfg_wr  = 1'b1;
                                    r_d.wdata   = r_q.sh;
                                    r_d.wr_done = 1'b1;
                                end
                            end
                            RK_GCALL: begin
                                if (r_q.sh == GC_RESET) begin
                                    r_d.oe   = 1'b1;
                                    r_d.srst = 1'b1;
                                end else if (r_q.sh == GC_KEEP) begin
                                    r_d.oe = 1'b1;
                                end
                            end
                            default: r_d.st = ST_IDLE;
                        endcase
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        r_d.oe  = 1'b0;
                        r_d.cnt = '0;
                        if (r_q.rd) begin
                            r_d.st  = ST_TX;
                            r_d.sh  = tx_byte;
                            r_d.oe  = ~tx_byte[BYTE_W-1];
                            r_d.idx = idx_next(r_q.idx);
                        end else begin
                            r_d.st = ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (r_q.cnt == CNT_W'(BYTE_W)) begin
                            r_d.st  = ST_TX_ACK;
                            r_d.oe  = 1'b0;
                            r_d.cnt = '0;
                        end else begin
                            r_d.sh = {r_q.sh[BYTE_W-2:0], 1'b1};
                            r_d.oe = ~r_q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        if (sda_s) begin
                            r_d.st = ST_IDLE;
                            r_d.rd = 1'b0;
                        end else begin
                            r_d.cnt = CNT_W'(1);
                        end
                    end else if (scl_fall && r_q.cnt == CNT_W'(1)) begin
                        r_d.st  = ST_TX;
                        r_d.cnt = '0;
                        r_d.sh  = tx_byte;
                        r_d.oe  = ~tx_byte[BYTE_W-1];
                        r_d.idx = idx_next(r_q.idx);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.kind <= RK_ADDR;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe_o    = r_q.oe;
    assign cfg_wr_o    = r_q.cfg_wr;
    assign cfg_wdata_o = r_q.wdata;
    assign soft_rst_o  = r_q.srst;
    assign hs_mode_o   = r_q.hs;

endmodule

// File: rtl/adc_i2c_target_chk.sv
module adc_i2c_target_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic stop_evt,
    input logic sda_oe_o,
    input logic cfg_wr_o,
    input logic soft_rst_o,
    input logic hs_mode_o
);
    // R8: the data drive holds while the synchronized clock stays high
    p_oe_hold_scl_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe_o));

    // R4: a configuration write strobe lasts one cycle
    p_cfg_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_o |=> !cfg_wr_o);

    // R5: the reset request lasts one cycle
    p_reset_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> !soft_rst_o);

    // R4 and R5 come from different transfers, never together
    p_strobes_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_wr_o, soft_rst_o}));

    // R7: the high-speed code is not acknowledged
    p_hs_no_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_mode_o) |-> !sda_oe_o);

    // R7: a stop clears high-speed mode
    p_hs_clear_on_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !hs_mode_o);

    // R11: a stop releases the data line
    p_release_on_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe_o);
endmodule

bind adc_i2c_target adc_i2c_target_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .stop_evt   (stop_evt),
    .sda_oe_o   (sda_oe_o),
    .cfg_wr_o   (cfg_wr_o),
    .soft_rst_o (soft_rst_o),
    .hs_mode_o  (hs_mode_o)
);

// File: tb/adc_i2c_target_tb_top.sv
module adc_i2c_target_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [2:0]  strap = 3'd0;
    logic [15:0] result = 16'h0000;
    logic [7:0]  cfg = 8'h8C;
    logic        sda_oe;
    logic        cfg_wr;
    logic [7:0]  cfg_wdata;
    logic        soft_rst;
    logic        hs_mode;
    wire         sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int rst_cnt = 0;
    int r8_viol = 0;
    int oe_seen = 0;
    logic [7:0] wr_last = 8'h00;
    logic oe_prev = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    adc_i2c_target dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .strap_i(strap), .result_i(result), .cfg_i(cfg), .cfg_wr_o(cfg_wr),
        .cfg_wdata_o(cfg_wdata), .soft_rst_o(soft_rst), .hs_mode_o(hs_mode)
    );

    // Strobe counters and the R8 monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (cfg_wr) begin wr_cnt++; wr_last = cfg_wdata; end
        if (soft_rst) rst_cnt++;
        if (sda_oe) oe_seen++;
        if (rst_n && sda_oe != oe_prev && scl_m) r8_viol++;
        oe_prev = sda_oe;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(5); scl_m = 1'b1; wt(10);
        sda_m = 1'b0; wt(10); scl_m = 1'b0; wt(5);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(5); scl_m = 1'b1; wt(10); sda_m = 1'b1; wt(10);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(5); scl_m = 1'b1; wt(10); scl_m = 1'b0; wt(5);
        end
        sda_m = 1'b1; wt(5); scl_m = 1'b1; wt(5);
        acked = ~sda_line;
        wt(5); scl_m = 1'b0; wt(5);
    endtask

    task automatic recv_byte(input bit master_ack, output logic [7:0] b);
        sda_m = 1'b1;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            wt(5); scl_m = 1'b1; wt(5); b = {b[6:0], sda_line}; wt(5); scl_m = 1'b0; wt(5);
        end
        sda_m = ~master_ack; wt(5); scl_m = 1'b1; wt(10); scl_m = 1'b0; wt(5);
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] exp_rd(input int idx, input logic [15:0] res,
                                          input logic [7:0] c);
        if (idx == 0) return res[15:8];
        if (idx == 1) return res[7:0];
        if (idx == 2) return c;
        return 8'hFF;
    endfunction

    function automatic logic [7:0] addr_of(input logic [2:0] s, input bit rd);
        return {4'b1001, s, rd};
    endfunction

    task automatic do_read(input int nbytes, input string req);
        bit a;
        logic [7:0] b;
        logic [15:0] res0;
        res0 = result;
        bus_start();
        send_byte(addr_of(strap, 1'b1), a);
        check(a, "R1 read address ack", a, 1);
        for (int i = 0; i < nbytes; i++) begin
            recv_byte(i != nbytes - 1, b);
            check(b == exp_rd(i, res0, cfg), req, b, exp_rd(i, res0, cfg));
        end
        bus_stop();
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        bit a;
        int w0, r0;
        logic [7:0] b;
        void'($urandom(32'h1ADC));
        wt(4);
        rst_n = 1'b1;
        wt(4);
        // R11 reset state
        check(!sda_oe, "R11 oe after reset", sda_oe, 0);
        check(!cfg_wr, "R11 cfg_wr after reset", cfg_wr, 0);
        check(!soft_rst, "R11 soft_rst after reset", soft_rst, 0);
        check(!hs_mode, "R11 hs_mode after reset", hs_mode, 0);

        // R2: full read with filler
        strap = 3'd5; result = 16'hA55A; cfg = 8'h8C;
        do_read(5, "R2 read byte order");

        // R3: result changes mid-read
        strap = 3'd2; result = 16'h1234;
        bus_start();
        send_byte(addr_of(strap, 1'b1), a);
        recv_byte(1'b1, b);
        check(b == 8'h12, "R3 high byte", b, 8'h12);
        result = 16'hBEEF;
        recv_byte(1'b0, b);
        check(b == 8'h34, "R3 low byte latched", b, 8'h34);
        bus_stop();

        // R1: wrong prefix and wrong strap not acknowledged
        bus_start();
        send_byte({4'b1011, strap, 1'b0}, a);
        check(!a, "R1 wrong prefix nack", a, 0);
        bus_stop();
        bus_start();
        send_byte(addr_of(strap ^ 3'd1, 1'b1), a);
        check(!a, "R1 wrong strap nack", a, 0);
        bus_stop();

        // R4: only first write byte taken
        w0 = wr_cnt;
        bus_start();
        send_byte(addr_of(strap, 1'b0), a);
        check(a, "R4 write address ack", a, 1);
        send_byte(8'h9B, a);
        check(a, "R4 first byte ack", a, 1);
        check(wr_cnt == w0 + 1 && wr_last == 8'h9B, "R4 first byte strobe", wr_last, 8'h9B);
        send_byte(8'h13, a);
        check(!a, "R4 second byte nack", a, 0);
        check(wr_cnt == w0 + 1, "R4 no second strobe", wr_cnt - w0, 1);
        bus_stop();

        // R5: general-call reset
        r0 = rst_cnt;
        bus_start();
        send_byte(8'h00, a);
        check(a, "R5 general call ack", a, 1);
        send_byte(8'h06, a);
        check(a && rst_cnt == r0 + 1, "R5 reset byte", rst_cnt - r0, 1);
        // R6: 04h acked without reset, 05h refused
        send_byte(8'h04, a);
        check(a && rst_cnt == r0 + 1, "R6 04h ack no reset", rst_cnt - r0, 1);
        send_byte(8'h05, a);
        check(!a, "R6 05h nack", a, 0);
        bus_stop();

        // R7: high-speed master code
        bus_start();
        send_byte(8'h0D, a);
        check(!a, "R7 hs code nack", a, 0);
        check(hs_mode, "R7 hs mode set", hs_mode, 1);
        bus_start();
        send_byte(addr_of(strap, 1'b1), a);
        check(a && hs_mode, "R7 hs held over repeated start", hs_mode, 1);
        recv_byte(1'b0, b);
        bus_stop();
        check(!hs_mode, "R7 hs cleared by stop", hs_mode, 0);
        check(!sda_oe, "R11 oe released after stop", sda_oe, 0);

        // R9: master nack then idle clocks
        bus_start();
        send_byte(addr_of(strap, 1'b1), a);
        recv_byte(1'b0, b);
        oe_seen = 0;
        recv_byte(1'b0, b);
        check(b == 8'hFF && oe_seen == 0, "R9 silent after nack", b, 8'hFF);
        bus_stop();

        // R10: repeated start from write into read
        result = 16'h7E01; cfg = 8'h1D;
        bus_start();
        send_byte(addr_of(strap, 1'b0), a);
        bus_start();
        send_byte(addr_of(strap, 1'b1), a);
        check(a, "R10 read address after repeated start", a, 1);
        recv_byte(1'b1, b);
        check(b == 8'h7E, "R10 high byte", b, 8'h7E);
        recv_byte(1'b0, b);
        check(b == 8'h01, "R10 low byte", b, 8'h01);
        bus_stop();

        // Random mix
        for (int it = 0; it < 24; it++) begin
            int op;
            op = int'($urandom_range(2, 0));
            strap = 3'($urandom);
            result = 16'($urandom);
            cfg = 8'($urandom);
            if (op == 0) begin
                do_read(int'($urandom_range(5, 1)), "R2 random read");
            end else if (op == 1) begin
                logic [7:0] d;
                d = 8'($urandom);
                w0 = wr_cnt;
                bus_start();
                send_byte(addr_of(strap, 1'b0), a);
                send_byte(d, a);
                send_byte(8'($urandom), a);
                bus_stop();
                check(wr_cnt == w0 + 1 && wr_last == d, "R4 random write", wr_last, d);
            end else begin
                logic [7:0] g;
                bit exp_a;
                g = (it % 4 == 0) ? 8'h06 : 8'($urandom);
                exp_a = (g == 8'h04) || (g == 8'h06);
                r0 = rst_cnt;
                bus_start();
                send_byte(8'h00, a);
                send_byte(g, a);
                bus_stop();
                check(a == exp_a, "R6 random general-call ack", a, exp_a);
                check(rst_cnt == r0 + ((g == 8'h06) ? 1 : 0), "R5 random reset count",
                      rst_cnt - r0, (g == 8'h06) ? 1 : 0);
            end
        end

        check(r8_viol == 0, "R8 drive changes with clock high", r8_viol, 0);
        done = 1'b1;
        finish_run();
    end
endmodule